// File: doc/BRIEF.md
# Dual-Latency Issue Interlock

This controller sits at the issue stage of a single-issue, fully interlocked pipeline that feeds two kinds of execution unit. The first is a one-cycle ALU for integer, logical and logarithmic multiply/divide work. The second is a non-pipelined logarithmic adder that needs three cycles per operation, or four when its range-shifting step is used. After an add starts, the controller keeps issuing one-cycle instructions in the adder's shadow. It holds back any instruction that touches a register the add will write. It also holds back a second add while the adder is occupied.

Two register-file write ports are driven. Port A retires the one-cycle ALU one cycle after issue. Port B retires the adder, and in vector mode it writes a consecutive register pair in one transfer. Both ports may fire in the same cycle. The controller also owns the 2-bit condition code, which only integer results update, and it resolves conditional branches against that code.

Top module: `ilk_issue_ctrl`

## Requirements
- R1: At most one instruction issues per cycle: `issue_o` is high exactly when `req_valid_i` is high and `stall_o` is low, and `stall_o` is never high without `req_valid_i`.
- R2: An op with code 0 (integer) or 1 (logarithmic one-cycle) that issues in cycle t raises `wb_a_en_o` in cycle t+1, with `wb_a_addr_o` equal to its destination.
- R3: An add (op code 2) that issues in cycle t raises `wb_b_en_o` with its destination on `wb_b_addr_o` in cycle t+3 when `req_long_i` is 0, and in cycle t+4 when `req_long_i` is 1, and at no earlier cycle.
- R4: While the adder is busy, a one-cycle op whose source and destination registers are all outside the add's destinations issues without a stall.
- R5: A one-cycle op whose first source, second source or destination equals a pending add destination stalls up to and including the add's writeback cycle, and issues in the cycle after it.
- R6: An add that arrives while the adder is busy, including its writeback cycle, stalls until the following cycle.
- R7: A vector add (`req_vec_i`=1) with destination d marks d and d+1 modulo 16 as pending, and retires with `wb_b_pair_o`=1.
- R8: Port A and port B may both be enabled in the same cycle.
- R9: At port-A writeback of an integer op, the condition code becomes 2'b10 if the result's MSB is set, 2'b00 if the result is zero, and 2'b01 otherwise.
- R10: Logarithmic one-cycle ops and adds leave the condition code unchanged.
- R11: A branch (op code 3) that issues drives `br_taken_o` high when its mask selects the current state: mask bit 0 zero, bit 1 positive, bit 2 negative.
- R12: A branch stalls for the one cycle in which an integer op is writing back, so that it is evaluated against the updated code.
- R13: After reset the adder is idle, both write ports are off, and the condition code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Decoded instruction is present |
| req_op_i | input | 2 | 0 integer, 1 logarithmic one-cycle, 2 logarithmic add/sub, 3 branch |
| req_rd_i | input | 4 | Destination register |
| req_rs_i | input | 4 | First source register |
| req_rt_i | input | 4 | Second source register |
| req_vec_i | input | 1 | Add covers a register pair |
| req_long_i | input | 1 | Add needs the four-cycle path |
| req_mask_i | input | 3 | Branch condition mask |
| alu_res_i | input | 32 | One-cycle ALU result during the port-A writeback cycle |
| issue_o | output | 1 | Instruction issues this cycle |
| stall_o | output | 1 | Instruction is held |
| add_start_o | output | 1 | Launch the adder |
| add_long_o | output | 1 | Launched add uses the four-cycle path |
| add_vec_o | output | 1 | Launched add is a pair |
| br_taken_o | output | 1 | Issued branch is taken |
| wb_a_en_o | output | 1 | One-cycle ALU write enable |
| wb_a_addr_o | output | 4 | One-cycle ALU write register |
| wb_b_en_o | output | 1 | Adder write enable |
| wb_b_addr_o | output | 4 | Adder write register (first of pair) |
| wb_b_pair_o | output | 1 | Adder writes two consecutive registers |
| cc_o | output | 2 | Condition code |

## Verification
The assertions assume a decoder that holds a stalled instruction steady until it issues. They also assume the ALU result is valid only in the port-A writeback cycle, and that register numbers stay inside the 16-entry file. The directed stimulus drives requests on the falling edge and holds every stalled request unchanged until it issues. It places a result on `alu_res_i` only in the cycle after a one-cycle op issues. It waits for the adder to drain before each scenario ends, so a lone add is in flight whenever the scoreboard is queried.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum logic [1:0] {
    OP_INT  = 2'd0,
    OP_LOG  = 2'd1,
    OP_LADD = 2'd2,
    OP_BR   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CC_ZERO = 2'b00,
    CC_POS  = 2'b01,
    CC_NEG  = 2'b10
  } cc_e;
endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard #(
  parameter int NREG = 16,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [AW-1:0] set_rd_i,
  input  logic          set_pair_i,
  input  logic          clr_i,
  input  logic [AW-1:0] q_rs_i,
  input  logic [AW-1:0] q_rt_i,
  input  logic [AW-1:0] q_rd_i,
  output logic          hit_o
);
  logic [NREG-1:0] pend_q;
  logic [AW-1:0]   rd_nxt;

  assign rd_nxt = (set_rd_i == AW'(NREG-1)) ? '0 : set_rd_i + 1'b1;

  for (genvar g = 0; g < NREG; g++) begin : g_pend
    logic mark;
    assign mark = set_i && ((set_rd_i == AW'(g)) || (set_pair_i && rd_nxt == AW'(g)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pend_q[g] <= 1'b0;
      else if (mark)  pend_q[g] <= 1'b1;
      else if (clr_i) pend_q[g] <= 1'b0;
    end
  end

  assign hit_o = pend_q[q_rs_i] | pend_q[q_rt_i] | pend_q[q_rd_i];

  // R7
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pend_q == '0);

  // R7
  pair_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> $countones(pend_q) == ($past(set_pair_i) ? 2 : 1));
endmodule

// File: rtl/ilk_addseq.sv
module ilk_addseq #(
  parameter int AW        = 4,
  parameter int LAT_SHORT = 3,
  parameter int LAT_LONG  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          long_i,
  input  logic          vec_i,
  input  logic [AW-1:0] rd_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] addr_o,
  output logic          pair_o
);
  localparam int CW = $clog2(LAT_LONG + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic          pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      pair_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= long_i ? CW'(LAT_LONG - 1) : CW'(LAT_SHORT - 1);
      addr_q <= rd_i;
      pair_q <= vec_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
  assign addr_o = addr_q;
  assign pair_o = pair_q;

  // R6
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/ilk_ccunit.sv
module ilk_ccunit
  import ilk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] res_i,
  input  logic          br_i,
  input  logic [2:0]    mask_i,
  output logic [1:0]    cc_o,
  output logic          taken_o,
  output logic          pend_o
);
  cc_e        cc_q;
  logic [2:0] state_hot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cc_q <= CC_ZERO;
    else if (we_i) begin
      if (res_i[DW-1])       cc_q <= CC_NEG;
      else if (res_i == '0)  cc_q <= CC_ZERO;
      else                   cc_q <= CC_POS;
    end
  end

  assign state_hot = {cc_q == CC_NEG, cc_q == CC_POS, cc_q == CC_ZERO};
  assign taken_o   = br_i && |(mask_i & state_hot);
  assign pend_o    = we_i;
  assign cc_o      = cc_q;

  // R9
  cc_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && res_i[DW-1] |=> cc_q == CC_NEG);

  // R10
  cc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cc_q));
endmodule

// File: rtl/ilk_issue_ctrl.sv
module ilk_issue_ctrl
  import ilk_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int DW        = 32,
  parameter int LAT_SHORT = 3,
  parameter int LAT_LONG  = 4,
  localparam int AW       = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_rd_i,
  input  logic [AW-1:0] req_rs_i,
  input  logic [AW-1:0] req_rt_i,
  input  logic          req_vec_i,
  input  logic          req_long_i,
  input  logic [2:0]    req_mask_i,
  input  logic [DW-1:0] alu_res_i,
  output logic          issue_o,
  output logic          stall_o,
  output logic          add_start_o,
  output logic          add_long_o,
  output logic          add_vec_o,
  output logic          br_taken_o,
  output logic          wb_a_en_o,
  output logic [AW-1:0] wb_a_addr_o,
  output logic          wb_b_en_o,
  output logic [AW-1:0] wb_b_addr_o,
  output logic          wb_b_pair_o,
  output logic [1:0]    cc_o
);
  op_e           op;
  logic          is_single;
  logic          sb_hit;
  logic          add_busy;
  logic          cc_pend;
  logic          wb_a_en_q;
  logic          wb_a_int_q;
  logic [AW-1:0] wb_a_addr_q;

  assign op        = op_e'(req_op_i);
  assign is_single = (op == OP_INT) || (op == OP_LOG);

  assign stall_o = req_valid_i && ((is_single && sb_hit) ||
                                   (op == OP_LADD && add_busy) ||
                                   (op == OP_BR && cc_pend));
  assign issue_o     = req_valid_i && !stall_o;
  assign add_start_o = issue_o && (op == OP_LADD);
  assign add_long_o  = add_start_o && req_long_i;
  assign add_vec_o   = add_start_o && req_vec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_a_en_q   <= 1'b0;
      wb_a_int_q  <= 1'b0;
      wb_a_addr_q <= '0;
    end else begin
      wb_a_en_q   <= issue_o && is_single;
      wb_a_int_q  <= issue_o && (op == OP_INT);
      wb_a_addr_q <= req_rd_i;
    end
  end

  assign wb_a_en_o   = wb_a_en_q;
  assign wb_a_addr_o = wb_a_addr_q;

  ilk_scoreboard #(.NREG(NREG), .AW(AW)) i_scoreboard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (add_start_o),
    .set_rd_i   (req_rd_i),
    .set_pair_i (req_vec_i),
    .clr_i      (wb_b_en_o),
    .q_rs_i     (req_rs_i),
    .q_rt_i     (req_rt_i),
    .q_rd_i     (req_rd_i),
    .hit_o      (sb_hit)
  );

  ilk_addseq #(.AW(AW), .LAT_SHORT(LAT_SHORT), .LAT_LONG(LAT_LONG)) i_addseq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (add_start_o),
    .long_i  (req_long_i),
    .vec_i   (req_vec_i),
    .rd_i    (req_rd_i),
    .busy_o  (add_busy),
    .done_o  (wb_b_en_o),
    .addr_o  (wb_b_addr_o),
    .pair_o  (wb_b_pair_o)
  );

  ilk_ccunit #(.DW(DW)) i_ccunit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wb_a_int_q),
    .res_i   (alu_res_i),
    .br_i    (issue_o && (op == OP_BR)),
    .mask_i  (req_mask_i),
    .cc_o    (cc_o),
    .taken_o (br_taken_o),
    .pend_o  (cc_pend)
  );

  // R2
  wb_a_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && is_single |=> wb_a_en_o && wb_a_addr_o == $past(req_rd_i));

  // R5
  distinct_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_a_en_o && wb_b_en_o && !wb_b_pair_o |-> wb_a_addr_o != wb_b_addr_o);

  // R1
  stall_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> req_valid_i && !issue_o);
endmodule

// File: tb/test_ilk_issue_ctrl.sv
module test_ilk_issue_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = '0;
  logic [3:0]  req_rd_i = '0, req_rs_i = '0, req_rt_i = '0;
  logic        req_vec_i = 1'b0, req_long_i = 1'b0;
  logic [2:0]  req_mask_i = '0;
  logic [31:0] alu_res_i = '0;
  logic        issue_o, stall_o, add_start_o, add_long_o, add_vec_o, br_taken_o;
  logic        wb_a_en_o, wb_b_en_o, wb_b_pair_o;
  logic [3:0]  wb_a_addr_o, wb_b_addr_o;
  logic [1:0]  cc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ilk_issue_ctrl i_ilk_issue_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_rd_i, .req_rs_i, .req_rt_i,
    .req_vec_i, .req_long_i, .req_mask_i, .alu_res_i, .issue_o, .stall_o,
    .add_start_o, .add_long_o, .add_vec_o, .br_taken_o, .wb_a_en_o, .wb_a_addr_o,
    .wb_b_en_o, .wb_b_addr_o, .wb_b_pair_o, .cc_o
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk_i);
    #1;
  endtask

  task automatic put(input logic [1:0] op, input logic [3:0] rd, input logic [3:0] rs,
                     input logic [3:0] rt, input logic vec, input logic lng,
                     input logic [2:0] mask);
    req_valid_i = 1'b1; req_op_i = op; req_rd_i = rd; req_rs_i = rs; req_rt_i = rt;
    req_vec_i = vec; req_long_i = lng; req_mask_i = mask;
    #1;
  endtask

  task automatic idle();
    req_valid_i = 1'b0; req_vec_i = 1'b0; req_long_i = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk(wb_a_en_o, 0, "R13 wb_a off");
    chk(wb_b_en_o, 0, "R13 wb_b off");
    chk(cc_o, 2'b00, "R13 cc zero");
    put(2'd2, 4'd0, 4'd0, 4'd0, 0, 0, 0);
    chk(stall_o, 0, "R13 adder idle");
    idle();
    chk(stall_o, 0, "R1 no stall without req");
    chk(issue_o, 0, "R1 no issue without req");
  endtask

  task automatic t_int_cc();
    put(2'd0, 4'd3, 4'd1, 4'd2, 0, 0, 0);
    chk(issue_o, 1, "R1 int issues");
    nxt(); idle(); alu_res_i = 32'h8000_0001;
    chk(wb_a_en_o, 1, "R2 wb_a en");
    chk(wb_a_addr_o, 3, "R2 wb_a addr");
    nxt();
    chk(cc_o, 2'b10, "R9 negative");
    put(2'd0, 4'd4, 4'd1, 4'd2, 0, 0, 0);
    nxt(); idle(); alu_res_i = 32'h0;
    nxt();
    chk(cc_o, 2'b00, "R9 zero");
    put(2'd0, 4'd5, 4'd1, 4'd2, 0, 0, 0);
    nxt(); idle(); alu_res_i = 32'h0000_0042;
    nxt();
    chk(cc_o, 2'b01, "R9 positive");
    alu_res_i = 32'h0;
  endtask

  task automatic t_short_add();
    put(2'd2, 4'd5, 4'd1, 4'd2, 0, 0, 0);
    chk(add_start_o, 1, "R3 short add launch");
    nxt(); put(2'd0, 4'd7, 4'd8, 4'd9, 0, 0, 0);
    chk(issue_o, 1, "R4 shadow issue");
    chk(wb_b_en_o, 0, "R3 not early t+1");
    nxt(); put(2'd0, 4'd9, 4'd5, 4'd0, 0, 0, 0);
    chk(stall_o, 1, "R5 raw stall");
    chk(wb_b_en_o, 0, "R3 not early t+2");
    nxt();
    chk(wb_b_en_o, 1, "R3 short wb t+3");
    chk(wb_b_addr_o, 5, "R3 short wb addr");
    chk(wb_b_pair_o, 0, "R3 short scalar");
    chk(stall_o, 1, "R5 stall in wb cycle");
    nxt();
    chk(issue_o, 1, "R5 issue after wb");
    nxt(); idle();
  endtask

  task automatic t_long_add();
    put(2'd2, 4'd4, 4'd1, 4'd2, 0, 1, 0);
    chk(add_long_o, 1, "R3 long launch");
    nxt(); idle();
    nxt();
    nxt();
    chk(wb_b_en_o, 0, "R3 long not at t+3");
    nxt();
    chk(wb_b_en_o, 1, "R3 long wb t+4");
    chk(wb_b_addr_o, 4, "R3 long wb addr");
    nxt();
  endtask

  task automatic t_busy_add();
    put(2'd2, 4'd1, 4'd3, 4'd4, 0, 0, 0);
    nxt(); put(2'd2, 4'd2, 4'd3, 4'd4, 0, 0, 0);
    chk(stall_o, 1, "R6 busy stall t+1");
    nxt();
    chk(stall_o, 1, "R6 busy stall t+2");
    nxt();
    chk(stall_o, 1, "R6 busy stall wb cycle");
    chk(wb_b_addr_o, 1, "R6 first add retires");
    nxt();
    chk(issue_o, 1, "R6 second add issues");
    nxt(); idle();
    nxt();
    nxt();
    chk(wb_b_en_o, 1, "R6 second add retires");
    chk(wb_b_addr_o, 2, "R6 second add addr");
    nxt();
  endtask

  task automatic t_vec_add();
    put(2'd2, 4'd15, 4'd1, 4'd2, 1, 0, 0);
    chk(add_vec_o, 1, "R7 vector launch");
    nxt(); put(2'd0, 4'd1, 4'd0, 4'd2, 0, 0, 0);
    chk(stall_o, 1, "R7 wrapped reg pending");
    nxt(); put(2'd1, 4'd14, 4'd3, 4'd4, 0, 0, 0);
    chk(issue_o, 1, "R7 neighbour free");
    nxt(); put(2'd0, 4'd15, 4'd3, 4'd4, 0, 0, 0);
    chk(stall_o, 1, "R7 first reg pending");
    chk(wb_b_en_o, 1, "R7 vector wb");
    chk(wb_b_pair_o, 1, "R7 pair flag");
    chk(wb_b_addr_o, 15, "R7 pair base");
    nxt();
    chk(issue_o, 1, "R7 released");
    nxt(); idle();
  endtask

  task automatic t_dual();
    put(2'd2, 4'd6, 4'd1, 4'd2, 0, 0, 0);
    nxt(); idle();
    nxt(); put(2'd1, 4'd8, 4'd1, 4'd1, 0, 0, 0);
    chk(issue_o, 1, "R4 second shadow issue");
    nxt(); idle();
    chk(wb_a_en_o, 1, "R8 port A same cycle");
    chk(wb_a_addr_o, 8, "R8 port A addr");
    chk(wb_b_en_o, 1, "R8 port B same cycle");
    chk(wb_b_addr_o, 6, "R8 port B addr");
    nxt();
  endtask

  task automatic t_log_cc();
    put(2'd0, 4'd1, 4'd2, 4'd3, 0, 0, 0);
    nxt(); idle(); alu_res_i = 32'h5;
    nxt();
    chk(cc_o, 2'b01, "R9 set positive");
    put(2'd1, 4'd2, 4'd3, 4'd4, 0, 0, 0);
    nxt(); idle(); alu_res_i = 32'h8000_0000;
    nxt(); alu_res_i = 32'h0;
    chk(cc_o, 2'b01, "R10 log op keeps cc");
    put(2'd2, 4'd3, 4'd4, 4'd5, 0, 0, 0);
    nxt(); idle();
    nxt();
    nxt();
    nxt();
    chk(cc_o, 2'b01, "R10 add keeps cc");
  endtask

  task automatic t_branch();
    put(2'd3, 4'd0, 4'd0, 4'd0, 0, 0, 3'b010);
    chk(issue_o, 1, "R11 branch issues");
    chk(br_taken_o, 1, "R11 positive taken");
    nxt(); put(2'd3, 4'd0, 4'd0, 4'd0, 0, 0, 3'b101);
    chk(br_taken_o, 0, "R11 not selected");
    nxt(); put(2'd0, 4'd1, 4'd2, 4'd3, 0, 0, 0);
    nxt(); put(2'd3, 4'd0, 4'd0, 4'd0, 0, 0, 3'b100); alu_res_i = 32'hFFFF_FFF0;
    #1;
    chk(stall_o, 1, "R12 branch waits for cc");
    chk(br_taken_o, 0, "R12 no resolve while stalled");
    nxt(); alu_res_i = 32'h0;
    chk(stall_o, 0, "R12 branch released");
    chk(br_taken_o, 1, "R11 negative taken");
    nxt(); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    nxt();
    t_reset();
    t_int_cc();
    t_short_add();
    t_long_add();
    t_busy_add();
    t_vec_add();
    t_dual();
    t_log_cc();
    t_branch();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule